// File: doc/BRIEF.md
# Configurable Timer/Counter Channel with Reload and PWM

This block is a single timer/counter channel reached through a small byte-wide register port. Software loads a 16-bit count, picks one of four operating modes and a count source, then sets a run bit. In the variable-width mode the count wraps at a boundary chosen from 9 to 16 bits. In the reload mode it runs over the full 16 bits and, instead of wrapping to zero, restarts from a separate pair of reload bytes.

In the PWM mode the low count byte is a free-running 8-bit ramp. A prescaler whose period comes from the low reload byte paces the ramp. The high count byte serves as the duty compare. The pulse appears on a dedicated output pin. In the counting modes the channel can advance on every system clock or on falling edges of an external input that is first synchronised. Every wrap of the active count sets a sticky overflow flag, and software clears it through the control register.

Top module: `ovt_timer`

## Requirements
- R1: After a synchronous reset every register reads back zero, and both `ovf_flag` and `pwm_pin_out` are low.
- R2: Register map at `reg_addr`: 0 count low byte, 1 count high byte, 2 reload low byte, 3 reload high byte, 4 mode, 5 control. Addresses 6 and 7 read zero. `reg_rdata` shows the register addressed at a clock edge, sampled before that edge's updates.
- R3: The mode register holds the mode in bits [1:0] (0 variable width, 1 reload, 2 PWM, 3 hold), the count source in bit 2 (1 = external edges) and the width field in bits [5:3]. Bits [7:6] read zero.
- R4: The control register holds the run bit in bit 0 and the overflow flag in bit 1. While the run bit is 0 the count does not change, except through direct writes.
- R5: In mode 0 the count width is 9 plus the width field. Each advance gives (count+1) masked to that width, so any bits above the width are cleared. When the masked count is all ones, the advance yields zero and is an overflow.
- R6: In mode 1 the count advances across 16 bits. An advance from 0xFFFF loads {reload high, reload low} and is an overflow.
- R7: The overflow flag sets on any overflow. It stays set until a control write with bit 1 equal to 0 clears it. A control write with bit 1 equal to 1 leaves it unchanged.
- R8: With the source bit set in mode 0 or 1, the count advances once per falling edge of `cnt_pin_in`, after a two-stage synchroniser, and never on plain clocks.
- R9: In mode 2 the low count byte advances once every (reload low + 1) run clocks. A write to the count low byte restarts the prescaler. The high byte does not change, and a wrap of the low byte from 0xFF is an overflow.
- R10: `pwm_pin_out` is a registered output. It is high in a cycle only if the previous cycle was running in mode 2 with the low count byte below the high count byte, so over each ramp period it is high for (compare × prescale period) clocks.
- R11: In mode 3 the count holds even while the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_pin_in | input | 1 | External count input (asynchronous) |
| pwm_pin_out | output | 1 | PWM output pin |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the channel with its default parameters: 8-bit data, giving a 16-bit count, and a two-stage synchroniser. With this build all eight width settings of mode 0 can be reached from a preset just below each boundary, including counts that carry bits above the chosen width. Because a full PWM ramp is only 256 prescaled steps, duty is measured exactly over whole periods at compare values of zero, mid-scale and 0xFF within a few hundred cycles. Edge counting is checked with slow pulses on the external input, and the reload and hold modes are driven through their wrap and idle cases.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

  typedef enum logic [1:0] {
    MD_VARW   = 2'd0,
    MD_RELOAD = 2'd1,
    MD_PWM    = 2'd2,
    MD_HOLD   = 2'd3
  } ovt_mode_e;

  typedef struct packed {
    logic [2:0] wfld;
    logic       ext_src;
    ovt_mode_e  mode;
  } ovt_cfg_t;

  localparam int CFG_W = $bits(ovt_cfg_t);

  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd1;
  localparam logic [2:0] A_RLD_LO = 3'd2;
  localparam logic [2:0] A_RLD_HI = 3'd3;
  localparam logic [2:0] A_MODE   = 3'd4;
  localparam logic [2:0] A_CTRL   = 3'd5;

endpackage

// File: rtl/ovt_sync_edge.sv
module ovt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  always_comb fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/ovt_regs.sv
module ovt_regs import ovt_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [2*DW-1:0] cnt_q,
  input  logic          ovf_set,
  output logic [2*DW-1:0] rld_q,
  output ovt_cfg_t      cfg_q,
  output logic          run_q,
  output logic          ovf_q,
  output logic [DW-1:0] rdata_q,
  output logic          cnt_lo_we,
  output logic          cnt_hi_we
);
  logic sel_rl, sel_rh, sel_md, sel_ct;
  logic [DW-1:0] rd_c;

  always_comb begin
    cnt_lo_we = wr && (addr == AW'(A_CNT_LO));
    cnt_hi_we = wr && (addr == AW'(A_CNT_HI));
    sel_rl    = wr && (addr == AW'(A_RLD_LO));
    sel_rh    = wr && (addr == AW'(A_RLD_HI));
    sel_md    = wr && (addr == AW'(A_MODE));
    sel_ct    = wr && (addr == AW'(A_CTRL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
      cfg_q <= '0;
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (sel_rl) rld_q[DW-1:0]    <= wdata;
      if (sel_rh) rld_q[2*DW-1:DW] <= wdata;
      if (sel_md) cfg_q <= ovt_cfg_t'(wdata[CFG_W-1:0]);
      if (sel_ct) run_q <= wdata[0];
      if (ovf_set)                  ovf_q <= 1'b1;
      else if (sel_ct && !wdata[1]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      AW'(A_CNT_LO): rd_c = cnt_q[DW-1:0];
      AW'(A_CNT_HI): rd_c = cnt_q[2*DW-1:DW];
      AW'(A_RLD_LO): rd_c = rld_q[DW-1:0];
      AW'(A_RLD_HI): rd_c = rld_q[2*DW-1:DW];
      AW'(A_MODE):   rd_c = {{(DW-CFG_W){1'b0}}, cfg_q};
      AW'(A_CTRL):   rd_c = {{(DW-2){1'b0}}, ovf_q, run_q};
      default:       rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_c;
  end
endmodule

// File: rtl/ovt_core.sv
module ovt_core import ovt_pkg::*; #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  ovt_cfg_t        cfg,
  input  logic [2*DW-1:0] rld,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  input  logic            fall,
  output logic [2*DW-1:0] cnt_q,
  output logic            adv,
  output logic            ovf_set,
  output logic            pwm_q
);
  localparam int CW   = 2 * DW;
  localparam int MINW = DW + 1;
  localparam int SW   = $clog2(CW + 1);

  logic [SW-1:0]  wsel;
  logic [CW-1:0]  mask;
  logic [CW-1:0]  cnt_n;
  logic [DW-1:0]  pre_q;
  logic           pstep;
  logic           cnt_mode;

  always_comb begin
    wsel     = SW'(MINW) + SW'(cfg.wfld);
    mask     = ~({CW{1'b1}} << wsel);
    cnt_mode = (cfg.mode == MD_VARW) || (cfg.mode == MD_RELOAD);
    adv      = run && cnt_mode && (cfg.ext_src ? fall : 1'b1);
    pstep    = run && (cfg.mode == MD_PWM) && (pre_q == rld[DW-1:0]);
  end

  always_comb begin
    cnt_n   = cnt_q;
    ovf_set = 1'b0;
    if (adv) begin
      if (cfg.mode == MD_VARW) begin
        if ((cnt_q & mask) == mask) begin
          cnt_n   = '0;
          ovf_set = 1'b1;
        end else begin
          cnt_n = (cnt_q + 1'b1) & mask;
        end
      end else begin
        if (cnt_q == '1) begin
          cnt_n   = rld;
          ovf_set = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
    if (pstep) begin
      cnt_n[DW-1:0] = cnt_q[DW-1:0] + 1'b1;
      ovf_set       = (cnt_q[DW-1:0] == '1);
    end
    if (wr_lo) cnt_n[DW-1:0]  = wdata;
    if (wr_hi) cnt_n[CW-1:DW] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (rst || wr_lo)                        pre_q <= '0;
    else if (run && cfg.mode == MD_PWM)      pre_q <= pstep ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run && (cfg.mode == MD_PWM) && (cnt_q[DW-1:0] < cnt_q[CW-1:DW]);
  end
endmodule

// File: rtl/ovt_timer.sv
module ovt_timer import ovt_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cnt_pin_in,
  output logic              pwm_pin_out,
  output logic              ovf_flag
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] cnt_q, rld_q;
  ovt_cfg_t      cfg_q;
  logic          run_q, ovf_set, cnt_adv, pin_fall;
  logic          cnt_lo_we, cnt_hi_we;

  ovt_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk), .rst (rst), .pin (cnt_pin_in), .fall (pin_fall)
  );

  ovt_regs #(.DW(DATA_W), .AW(ADDR_W)) regs_i (
    .clk (clk), .rst (rst), .wr (reg_wr), .addr (reg_addr), .wdata (reg_wdata),
    .cnt_q (cnt_q), .ovf_set (ovf_set), .rld_q (rld_q), .cfg_q (cfg_q),
    .run_q (run_q), .ovf_q (ovf_flag), .rdata_q (reg_rdata),
    .cnt_lo_we (cnt_lo_we), .cnt_hi_we (cnt_hi_we)
  );

  ovt_core #(.DW(DATA_W)) core_i (
    .clk (clk), .rst (rst), .run (run_q), .cfg (cfg_q), .rld (rld_q),
    .wr_lo (cnt_lo_we), .wr_hi (cnt_hi_we), .wdata (reg_wdata), .fall (pin_fall),
    .cnt_q (cnt_q), .adv (cnt_adv), .ovf_set (ovf_set), .pwm_q (pwm_pin_out)
  );
endmodule

// File: rtl/ovt_timer_chk.sv
module ovt_timer_chk import ovt_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            ovf_flag,
  input logic            pwm_pin_out,
  input logic [2*DW-1:0] cnt_q,
  input logic [2*DW-1:0] rld_q,
  input ovt_cfg_t        cfg,
  input logic            run,
  input logic            adv
);
  localparam int CW = 2 * DW;
  logic [CW-1:0] wmask;
  always_comb wmask = ~({CW{1'b1}} << (DW + 1 + int'(cfg.wfld)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ovf_flag && !pwm_pin_out));

  // R5
  varw_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.mode == MD_VARW && adv && !reg_wr && ((cnt_q & wmask) == wmask)) |-> (cnt_q == '0));

  // R6
  reload_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.mode == MD_RELOAD && adv && !reg_wr && cnt_q == '1) |-> (cnt_q == $past(rld_q)));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(reg_wr && reg_addr == AW'(A_CTRL) && !reg_wdata[1]));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(run));

  // R10
  pwm_mode_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_pin_out |-> $past(run && cfg.mode == MD_PWM));

  // R11
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.mode == MD_HOLD && !reg_wr) |-> $stable(cnt_q));

  // R4
  stopped_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!run && !reg_wr) |-> $stable(cnt_q));
endmodule

bind ovt_timer ovt_timer_chk #(.DW(DATA_W), .AW(ADDR_W)) chk_i (
  .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
  .reg_wdata (reg_wdata), .ovf_flag (ovf_flag), .pwm_pin_out (pwm_pin_out),
  .cnt_q (cnt_q), .rld_q (rld_q), .cfg (cfg_q), .run (run_q), .adv (cnt_adv)
);

// File: tb/ovt_timer_tb.sv
`timescale 1ns/1ps
module ovt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin_in = 1'b1;
  logic       pwm_pin_out;
  logic       ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ovt_timer dut_i (
    .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cnt_pin_in (cnt_pin_in),
    .pwm_pin_out (pwm_pin_out), .ovf_flag (ovf_flag)
  );

  typedef struct packed {
    logic [2:0]  f;
    logic [15:0] st;
    logic [7:0]  n;
    logic [15:0] ex;
    logic        ov;
  } vec_t;

  // R5 width-boundary vectors: field, start, advances, expected count, expected flag
  localparam vec_t VEC [6] = '{
    '{3'd0, 16'h01FE, 8'd3, 16'h0001, 1'b1},
    '{3'd7, 16'hFFFD, 8'd2, 16'hFFFF, 1'b0},
    '{3'd3, 16'h0FFF, 8'd1, 16'h0000, 1'b1},
    '{3'd5, 16'h0010, 8'd5, 16'h0015, 1'b0},
    '{3'd0, 16'h0FFE, 8'd2, 16'h0000, 1'b1},
    '{3'd7, 16'hFFFF, 8'd1, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = {hi, lo};
  endtask

  // exactly n advances of a free-running count, flag preserved
  task automatic run_for(input int n);
    wr(3'd5, 8'h01);
    repeat (n - 1) @(negedge clk);
    wr(3'd5, 8'h02);
  endtask

  task automatic pwm_meas(input logic [7:0] presc, input logic [7:0] cmp,
                          input int win, input int exp_hi, input string tag);
    int hi_cnt;
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h02);
    wr(3'd2, presc);
    wr(3'd1, cmp);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h01);
    repeat (20) @(negedge clk);
    hi_cnt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_pin_out) hi_cnt++;
    end
    chk(tag, 16'(hi_cnt), 16'(exp_hi));
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      chk("R1 reset register", {8'h00, b}, 16'h0000);
    end
    chk("R1 reset ovf_flag", {15'd0, ovf_flag}, 16'd0);
    chk("R1 reset pwm_pin_out", {15'd0, pwm_pin_out}, 16'd0);

    // R5 R7 vector table for the variable-width mode
    for (int k = 0; k < 6; k++) begin
      wr(3'd4, {2'b00, VEC[k].f, 3'b000});
      wr(3'd0, VEC[k].st[7:0]);
      wr(3'd1, VEC[k].st[15:8]);
      wr(3'd5, 8'h00);
      run_for(int'(VEC[k].n));
      rd16(v);
      chk("R5 width count", v, VEC[k].ex);
      chk("R7 width overflow", {15'd0, ovf_flag}, {15'd0, VEC[k].ov});
    end

    // R2 R3 readback of configuration and unused addresses
    wr(3'd4, 8'hFF);
    rd(3'd4, b);
    chk("R3 mode readback", {8'h00, b}, 16'h003F);
    rd(3'd6, b);
    chk("R2 unused addr 6", {8'h00, b}, 16'h0000);
    rd(3'd7, b);
    chk("R2 unused addr 7", {8'h00, b}, 16'h0000);

    // R6 reload mode
    wr(3'd4, 8'h01);
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd0, 8'hFE);
    wr(3'd1, 8'hFF);
    wr(3'd5, 8'h00);
    run_for(3);
    rd16(v);
    chk("R6 reload count", v, 16'h1235);
    chk("R6 reload overflow", {15'd0, ovf_flag}, 16'd1);

    // R7 flag clearing rule
    wr(3'd5, 8'h02);
    chk("R7 write one keeps flag", {15'd0, ovf_flag}, 16'd1);
    rd(3'd5, b);
    chk("R7 ctrl readback", {8'h00, b}, 16'h0002);
    wr(3'd5, 8'h00);
    chk("R7 write zero clears", {15'd0, ovf_flag}, 16'd0);

    // R4 stopped count holds
    wr(3'd4, 8'h38);
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'h5A);
    repeat (10) @(negedge clk);
    rd16(v);
    chk("R4 stopped hold", v, 16'h5AA5);

    // R11 hold mode while running
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h00);
    run_for(10);
    rd16(v);
    chk("R11 hold mode", v, 16'h0055);

    // R8 external falling edges
    wr(3'd4, 8'h3C);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    for (int p = 0; p < 3; p++) begin
      cnt_pin_in = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    cnt_pin_in = 1'b0;
    repeat (8) @(negedge clk);
    wr(3'd5, 8'h00);
    cnt_pin_in = 1'b1;
    rd16(v);
    chk("R8 edge count", v, 16'h0004);

    // R9 prescaled ramp step count
    wr(3'd4, 8'h02);
    wr(3'd2, 8'h04);
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h00);
    run_for(25);
    rd16(v);
    chk("R9 prescaled steps", v, 16'h1005);
    chk("R9 no overflow yet", {15'd0, ovf_flag}, 16'd0);

    // R10 duty over whole periods
    pwm_meas(8'h00, 8'h80, 512, 256, "R10 duty half");
    chk("R9 ramp overflow", {15'd0, ovf_flag}, 16'd1);
    pwm_meas(8'h01, 8'h03, 1024, 12, "R10 duty prescaled");
    pwm_meas(8'h00, 8'h00, 256, 0, "R10 duty zero");
    pwm_meas(8'h00, 8'hFF, 256, 255, "R10 duty full");
    wr(3'd5, 8'h00);
    @(negedge clk);
    chk("R10 low when stopped", {15'd0, pwm_pin_out}, 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule